// File: doc/BRIEF.md
# Memory Protection Entry Register Bank

This block stores the settings of a set of physical memory protection entries: one 8-bit configuration byte and one XLEN-wide address word per entry. It also holds a small security-policy register with three bits. Software reaches these through a simple register bus. Configuration bytes travel packed, one byte per lane of the bus word. The address words and the policy register are each one word.

Each write passes through the locking rules before any state changes. The rules look at the entry's own lock bit and at whether the next entry is a locked top-of-range rule. They also look at the lockdown and bypass bits of the policy register. A write that the rules refuse, or that targets an entry beyond the implemented count, leaves the state untouched.

Every stored setting is exported flat to the region decoder that follows. A one-cycle change pulse tells the decoder to refresh. A per-entry dirty mask names the entries whose decoded range must be recomputed.

Top module: `pmp_cfg_bank`

## Requirements
- R1: A configuration write to word index k places bits 8i+7:8i of the data into entry k*LANES+i, where LANES = XLEN/8. A read of word k returns the bytes in the same lanes. Within a byte, bit 0 is read, bit 1 is write, bit 2 is execute, bits 4:3 are the match mode (01 = top-of-range) and bit 7 is lock.
- R2: An address write to index n stores the full word into entry n, and a read of index n returns it.
- R3: With the bypass bit clear, an entry whose lock bit is set ignores address writes. It also ignores configuration writes while lockdown is clear.
- R4: A write to address n is ignored when entry n+1 has its lock bit set and its mode is top-of-range.
- R5: With lockdown set, a configuration write is accepted only in these cases: the bypass bit is set; or the new byte sets lock and clears execute; or the new byte clears lock and its low three bits differ from 3'b110.
- R6: The policy register has lockdown at bit 0, whitelist-default at bit 1 and bypass at bit 2. Once set, lockdown and whitelist-default stay set until reset. Bypass cannot go from 0 to 1 while any entry has its lock bit set.
- R7: When the parameter ENHANCED is 0, all three policy bits are written as zero, and locks cannot be bypassed.
- R8: Writes to entries at or beyond NUM_ENTRIES are ignored, and reads of them return zero. A select of 3 also reads zero.
- R9: change_pulse is high for exactly the cycle after a write that changed a configuration byte, an address word, lockdown or whitelist-default. A write that changes nothing gives no pulse.
- R10: range_dirty, valid in the same cycle as the pulse, flags every entry whose byte or address changed. On an address change at n, it also flags entry n+1 when that entry is in top-of-range mode.
- R11: After reset every register, the pulse and the dirty mask read zero.
- R12: With the bypass bit set, locked entries accept configuration and address writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus access strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 2 | 0 configuration, 1 address, 2 policy, 3 none |
| req_index | input | INDEX_W | Word or entry index |
| req_wdata | input | XLEN | Write data |
| rd_data | output | XLEN | Read data, combinational on select and index |
| entry_cfg | output | NUM_ENTRIES*8 | All configuration bytes, entry e at bits 8e+7:8e |
| entry_addr | output | NUM_ENTRIES*XLEN | All address words, entry e at slice e |
| sec_mml | output | 1 | Lockdown bit |
| sec_mmwp | output | 1 | Whitelist-default bit |
| sec_rlb | output | 1 | Lock bypass bit |
| change_pulse | output | 1 | One-cycle notice of an effective change |
| range_dirty | output | NUM_ENTRIES | Entries whose decoded range needs refreshing |

## Verification
A wrong lock decision corrupts state silently. It shows up at the first read-back after the write, and in a change pulse that is present or missing one cycle after the write edge. Every write in the sweeps is therefore followed by a read and a pulse check against a model built from the requirements. A dropped top-of-range refresh shows only in range_dirty, in that same cycle. Stickiness errors in the policy register show when a later clearing write reads back.

// File: rtl/pmp_bank_pkg.sv
package pmp_bank_pkg;
  localparam int CFG_R = 0;
  localparam int CFG_W = 1;
  localparam int CFG_X = 2;
  localparam int CFG_L = 7;
  localparam int SEC_MML  = 0;
  localparam int SEC_MMWP = 1;
  localparam int SEC_RLB  = 2;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_TOR   = 2'd1,
    MODE_NA4   = 2'd2,
    MODE_NAPOT = 2'd3
  } match_mode_e;

  typedef enum logic [1:0] {
    SEL_CFG  = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_SEC  = 2'd2,
    SEL_NONE = 2'd3
  } bus_sel_e;

  function automatic logic cfg_write_ok(input logic enh, input logic [7:0] cur,
                                        input logic [7:0] nv, input logic rlb,
                                        input logic mml);
    logic locked;
    logic ok;
    locked = cur[CFG_L] & ~rlb;
    if (!enh) begin
      ok = ~locked;
    end else begin
      ok = rlb
         | (~mml & ~locked)
         | (mml & nv[CFG_L] & ~nv[CFG_X])
         | (mml & ~nv[CFG_L] & (nv[2:0] != 3'b110));
    end
    return ok;
  endfunction
endpackage

// File: rtl/pmp_entry.sv
module pmp_entry
  import pmp_bank_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter bit ENHANCED = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [7:0]      cfg_wval,
  input  logic            addr_we,
  input  logic [XLEN-1:0] addr_wval,
  input  logic            rlb,
  input  logic            mml,
  input  logic            next_lock_tor,
  output logic [7:0]      cfg_q,
  output logic [XLEN-1:0] addr_q,
  output logic            lock_tor,
  output logic            cfg_chg,
  output logic            addr_chg
);
  logic            locked;
  logic            cfg_ok;
  logic            addr_ok;
  logic [7:0]      cfg_d;
  logic [XLEN-1:0] addr_d;

  always_comb begin
    locked   = cfg_q[CFG_L] & ~rlb;
    cfg_ok   = cfg_write_ok(ENHANCED, cfg_q, cfg_wval, rlb, mml);
    addr_ok  = ~locked & ~next_lock_tor;
    cfg_chg  = cfg_we & cfg_ok & (cfg_wval != cfg_q);
    addr_chg = addr_we & addr_ok & (addr_wval != addr_q);
    cfg_d    = cfg_chg ? cfg_wval : cfg_q;
    addr_d   = addr_chg ? addr_wval : addr_q;
    lock_tor = cfg_q[CFG_L] & (cfg_q[4:3] == MODE_TOR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_chg) begin
      cfg_q <= cfg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_chg) begin
      addr_q <= addr_d;
    end
  end

  // R3: a locked entry keeps its byte outside lockdown
  a_r3_cfg_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[CFG_L] && !rlb && !mml) |=> $stable(cfg_q));
  // R3: a locked entry keeps its address
  a_r3_addr_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[CFG_L] && !rlb) |=> $stable(addr_q));
  // R4: locked top-of-range neighbour guards this address
  a_r4_tor_guard: assert property (@(posedge clk) disable iff (!rst_n)
    next_lock_tor |=> $stable(addr_q));
  // R5: lockdown refuses lock-plus-execute on a locked entry
  a_r5_mml_exec_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && mml && !rlb && cfg_q[CFG_L] && cfg_wval[CFG_L] && cfg_wval[CFG_X])
    |=> $stable(cfg_q));
endmodule

// File: rtl/pmp_sec_reg.sv
module pmp_sec_reg
  import pmp_bank_pkg::*;
#(
  parameter bit ENHANCED = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [2:0] wval,
  input  logic       any_lock,
  output logic       mml,
  output logic       mmwp,
  output logic       rlb,
  output logic       sticky_chg
);
  logic mml_d;
  logic mmwp_d;
  logic rlb_d;
  logic upd;

  always_comb begin
    mml_d  = mml;
    mmwp_d = mmwp;
    rlb_d  = rlb;
    if (we) begin
      if (ENHANCED) begin
        mml_d  = wval[SEC_MML] | mml;
        mmwp_d = wval[SEC_MMWP] | mmwp;
        rlb_d  = wval[SEC_RLB] & (rlb | ~any_lock);
      end else begin
        mml_d  = 1'b0;
        mmwp_d = 1'b0;
        rlb_d  = 1'b0;
      end
    end
    sticky_chg = (mml_d != mml) | (mmwp_d != mmwp);
    upd        = sticky_chg | (rlb_d != rlb);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mml  <= 1'b0;
      mmwp <= 1'b0;
      rlb  <= 1'b0;
    end else if (upd) begin
      mml  <= mml_d;
      mmwp <= mmwp_d;
      rlb  <= rlb_d;
    end
  end

  a_r6_mml_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    mml |=> mml);
  a_r6_mmwp_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    mmwp |=> mmwp);
  a_r6_rlb_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (!rlb && any_lock) |=> !rlb);
endmodule

// File: rtl/pmp_cfg_bank.sv
module pmp_cfg_bank
  import pmp_bank_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int XLEN        = 32,
  parameter int INDEX_W     = 6,
  parameter bit ENHANCED    = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic                        req_write,
  input  logic [1:0]                  req_sel,
  input  logic [INDEX_W-1:0]          req_index,
  input  logic [XLEN-1:0]             req_wdata,
  output logic [XLEN-1:0]             rd_data,
  output logic [NUM_ENTRIES*8-1:0]    entry_cfg,
  output logic [NUM_ENTRIES*XLEN-1:0] entry_addr,
  output logic                        sec_mml,
  output logic                        sec_mmwp,
  output logic                        sec_rlb,
  output logic                        change_pulse,
  output logic [NUM_ENTRIES-1:0]      range_dirty
);
  localparam int LANES = XLEN / 8;

  logic [1:0] rst_sync;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  logic                   wr_cfg, wr_addr, wr_sec;
  logic [7:0]             cfg_arr  [NUM_ENTRIES];
  logic [XLEN-1:0]        addr_arr [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] cfg_we, addr_we, cfg_chg, addr_chg, lock_tor, next_lt;
  logic [NUM_ENTRIES-1:0] lock_bits, tor_follow, dirty_d;
  logic                   sticky_chg, pulse_d;

  assign wr_cfg  = req_valid & req_write & (req_sel == SEL_CFG);
  assign wr_addr = req_valid & req_write & (req_sel == SEL_ADDR);
  assign wr_sec  = req_valid & req_write & (req_sel == SEL_SEC);
  assign next_lt = {1'b0, lock_tor[NUM_ENTRIES-1:1]};

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
    assign cfg_we[e]  = wr_cfg & (int'(req_index) == e / LANES);
    assign addr_we[e] = wr_addr & (int'(req_index) == e);

    pmp_entry #(.XLEN(XLEN), .ENHANCED(ENHANCED)) u_entry (
      .clk          (clk),
      .rst_n        (rst_ni),
      .cfg_we       (cfg_we[e]),
      .cfg_wval     (req_wdata[8*(e%LANES) +: 8]),
      .addr_we      (addr_we[e]),
      .addr_wval    (req_wdata),
      .rlb          (sec_rlb),
      .mml          (sec_mml),
      .next_lock_tor(next_lt[e]),
      .cfg_q        (cfg_arr[e]),
      .addr_q       (addr_arr[e]),
      .lock_tor     (lock_tor[e]),
      .cfg_chg      (cfg_chg[e]),
      .addr_chg     (addr_chg[e])
    );

    assign entry_cfg[8*e +: 8]       = cfg_arr[e];
    assign entry_addr[XLEN*e +: XLEN] = addr_arr[e];
    assign lock_bits[e]              = cfg_arr[e][CFG_L];

    if (e == 0) begin : g_first
      assign tor_follow[e] = 1'b0;
    end else begin : g_rest
      assign tor_follow[e] = addr_chg[e-1] & (cfg_arr[e][4:3] == MODE_TOR);
    end
    assign dirty_d[e] = cfg_chg[e] | addr_chg[e] | tor_follow[e];
  end

  pmp_sec_reg #(.ENHANCED(ENHANCED)) u_sec (
    .clk       (clk),
    .rst_n     (rst_ni),
    .we        (wr_sec),
    .wval      (req_wdata[2:0]),
    .any_lock  (|lock_bits),
    .mml       (sec_mml),
    .mmwp      (sec_mmwp),
    .rlb       (sec_rlb),
    .sticky_chg(sticky_chg)
  );

  assign pulse_d = (|cfg_chg) | (|addr_chg) | sticky_chg;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      change_pulse <= 1'b0;
      range_dirty  <= '0;
    end else begin
      change_pulse <= pulse_d;
      range_dirty  <= dirty_d;
    end
  end

  always_comb begin
    rd_data = '0;
    case (req_sel)
      SEL_CFG: begin
        for (int e = 0; e < NUM_ENTRIES; e++) begin
          if (int'(req_index) == e / LANES) rd_data[8*(e%LANES) +: 8] = cfg_arr[e];
        end
      end
      SEL_ADDR: begin
        for (int e = 0; e < NUM_ENTRIES; e++) begin
          if (int'(req_index) == e) rd_data = addr_arr[e];
        end
      end
      SEL_SEC: begin
        rd_data[SEC_MML]  = sec_mml;
        rd_data[SEC_MMWP] = sec_mmwp;
        rd_data[SEC_RLB]  = sec_rlb;
      end
      default: rd_data = '0;
    endcase
  end

  // R9: a pulse only follows a real change of exported settings
  a_r9_pulse_real: assert property (@(posedge clk) disable iff (!rst_ni)
    change_pulse |-> ((entry_cfg != $past(entry_cfg)) || (entry_addr != $past(entry_addr))
                      || (sec_mml != $past(sec_mml)) || (sec_mmwp != $past(sec_mmwp))));
  // R9: every real change is announced
  a_r9_pulse_complete: assert property (@(posedge clk) disable iff (!rst_ni)
    ((entry_cfg != $past(entry_cfg)) || (entry_addr != $past(entry_addr))) |-> change_pulse);
  // R10: dirty flags come only with the pulse
  a_r10_dirty_with_pulse: assert property (@(posedge clk) disable iff (!rst_ni)
    (range_dirty != '0) |-> change_pulse);
endmodule

// File: tb/pmp_cfg_bank_test.sv
module pmp_cfg_bank_test;
  localparam int N = 16;
  localparam int XL = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]    req_sel = 2'd3;
  logic [5:0]    req_index = '0;
  logic [XL-1:0] req_wdata = '0;
  logic [XL-1:0] rd_data;
  logic [N*8-1:0] entry_cfg;
  logic [N*XL-1:0] entry_addr;
  logic sec_mml, sec_mmwp, sec_rlb, change_pulse;
  logic [N-1:0] range_dirty;

  logic          b_valid = 1'b0, b_write = 1'b0;
  logic [1:0]    b_sel = 2'd3;
  logic [5:0]    b_index = '0;
  logic [XL-1:0] b_wdata = '0;
  logic [XL-1:0] b_rd;
  logic [N*8-1:0] b_cfg;
  logic [N*XL-1:0] b_addr;
  logic b_mml, b_mmwp, b_rlb, b_pulse;
  logic [N-1:0] b_dirty;

  pmp_cfg_bank #(.NUM_ENTRIES(N), .XLEN(XL), .INDEX_W(6), .ENHANCED(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_sel(req_sel), .req_index(req_index), .req_wdata(req_wdata), .rd_data(rd_data),
    .entry_cfg(entry_cfg), .entry_addr(entry_addr), .sec_mml(sec_mml), .sec_mmwp(sec_mmwp),
    .sec_rlb(sec_rlb), .change_pulse(change_pulse), .range_dirty(range_dirty));

  pmp_cfg_bank #(.NUM_ENTRIES(N), .XLEN(XL), .INDEX_W(6), .ENHANCED(1'b0)) uut_base (
    .clk(clk), .rst_n(rst_n), .req_valid(b_valid), .req_write(b_write),
    .req_sel(b_sel), .req_index(b_index), .req_wdata(b_wdata), .rd_data(b_rd),
    .entry_cfg(b_cfg), .entry_addr(b_addr), .sec_mml(b_mml), .sec_mmwp(b_mmwp),
    .sec_rlb(b_rlb), .change_pulse(b_pulse), .range_dirty(b_dirty));

  int total = 0;
  int bad = 0;

  logic [7:0]    m_cfg  [N];
  logic [XL-1:0] m_addr [N];
  logic m_mml = 1'b0, m_mmwp = 1'b0, m_rlb = 1'b0;

  task automatic chk(input string tag, input logic [XL-1:0] act, input logic [XL-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [XL-1:0] model_read(input logic [1:0] sel, input int idx);
    logic [XL-1:0] w = '0;
    if (sel == 2'd0) begin
      for (int i = 0; i < 4; i++) if (idx*4+i < N) w[8*i +: 8] = m_cfg[idx*4+i];
    end else if (sel == 2'd1) begin
      if (idx < N) w = m_addr[idx];
    end else if (sel == 2'd2) begin
      w = {29'd0, m_rlb, m_mmwp, m_mml};
    end
    return w;
  endfunction

  // Expected effect of a write, from R1..R12
  task automatic model_apply(input logic [1:0] sel, input int idx, input logic [XL-1:0] d,
                             output logic p, output logic [N-1:0] dm);
    p = 1'b0; dm = '0;
    if (sel == 2'd0) begin
      for (int i = 0; i < 4; i++) begin
        int e = idx*4 + i;
        if (e < N) begin
          logic [7:0] v = d[8*i +: 8];
          logic lk = m_cfg[e][7] & ~m_rlb;
          logic ok = m_rlb | (~m_mml & ~lk) | (m_mml & v[7] & ~v[2])
                   | (m_mml & ~v[7] & (v[2:0] != 3'b110));
          if (ok && v != m_cfg[e]) begin m_cfg[e] = v; p = 1'b1; dm[e] = 1'b1; end
        end
      end
    end else if (sel == 2'd1) begin
      if (idx < N) begin
        logic ok = !(m_cfg[idx][7] && !m_rlb);
        if (idx+1 < N && m_cfg[idx+1][7] && m_cfg[idx+1][4:3] == 2'b01) ok = 1'b0;
        if (ok && d != m_addr[idx]) begin
          m_addr[idx] = d; p = 1'b1; dm[idx] = 1'b1;
          if (idx+1 < N && m_cfg[idx+1][4:3] == 2'b01) dm[idx+1] = 1'b1;
        end
      end
    end else if (sel == 2'd2) begin
      logic any_l = 1'b0;
      logic nm, nw;
      for (int e = 0; e < N; e++) any_l |= m_cfg[e][7];
      nm = d[0] | m_mml; nw = d[1] | m_mmwp;
      m_rlb = d[2] & (m_rlb | ~any_l);
      if (nm != m_mml || nw != m_mmwp) p = 1'b1;
      m_mml = nm; m_mmwp = nw;
    end
  endtask

  task automatic bus_write(input logic [1:0] sel, input int idx, input logic [XL-1:0] d,
                           input string tag);
    logic ep;
    logic [N-1:0] ed;
    model_apply(sel, idx, d, ep, ed);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_sel = sel; req_index = idx[5:0]; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    chk({tag, " R9 pulse"}, {31'd0, change_pulse}, {31'd0, ep});
    chk({tag, " R10 dirty"}, {16'd0, range_dirty}, {16'd0, ed});
  endtask

  task automatic bus_read(input logic [1:0] sel, input int idx, input string tag);
    req_sel = sel; req_index = idx[5:0];
    #1;
    chk(tag, rd_data, model_read(sel, idx));
  endtask

  task automatic b_wr(input logic [1:0] sel, input int idx, input logic [XL-1:0] d);
    @(negedge clk);
    b_valid = 1'b1; b_write = 1'b1; b_sel = sel; b_index = idx[5:0]; b_wdata = d;
    @(negedge clk);
    b_valid = 1'b0; b_write = 1'b0;
  endtask

  task automatic b_rdchk(input logic [1:0] sel, input int idx, input logic [XL-1:0] exp,
                         input string tag);
    b_sel = sel; b_index = idx[5:0];
    #1;
    chk(tag, b_rd, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int e = 0; e < N; e++) begin m_cfg[e] = '0; m_addr[e] = '0; end
    #2;
    // R11: reset state
    for (int k = 0; k < 5; k++) bus_read(2'd0, k, "R11 cfg reset");
    for (int k = 0; k < 17; k++) bus_read(2'd1, k, "R11 addr reset");
    bus_read(2'd2, 0, "R11 sec reset");
    chk("R11 pulse reset", {31'd0, change_pulse}, 32'd0);
    chk("R11 dirty reset", {16'd0, range_dirty}, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: packed lanes, many unlocked byte patterns
    for (int v = 0; v < 128; v++) begin
      for (int k = 0; k < 4; k++) begin
        logic [XL-1:0] w;
        for (int i = 0; i < 4; i++) w[8*i +: 8] = 8'((v*7 + k*29 + i*53) & 8'h67);
        bus_write(2'd0, k, w, "R1 cfg write");
        bus_read(2'd0, k, "R1 cfg readback");
      end
    end
    for (int k = 0; k < 4; k++) bus_write(2'd0, k, 32'd0, "R1 cfg clear");
    chk("R1 flat lanes", entry_cfg[31:0], 32'd0);

    // R2 and R8: address words, out-of-range indices
    for (int n = 0; n < 21; n++) begin
      bus_write(2'd1, n, 32'h1000_0000 + n * 32'h0001_0101, "R2 R8 addr write");
      bus_read(2'd1, n, "R2 R8 addr readback");
    end
    for (int k = 4; k < 8; k++) begin
      bus_write(2'd0, k, 32'hFFFF_FFFF, "R8 cfg oob write");
      bus_read(2'd0, k, "R8 cfg oob read");
    end
    bus_read(2'd3, 0, "R8 none select");

    // R9: same value gives no pulse; the pulse lasts one cycle
    bus_write(2'd1, 3, m_addr[3], "R9 same value");
    bus_write(2'd1, 3, 32'hCAFE_0003, "R9 new value");
    @(negedge clk);
    chk("R9 pulse one cycle", {31'd0, change_pulse}, 32'd0);

    // R10: top-of-range follower flagged
    bus_write(2'd0, 1, 32'h0000_0800, "R10 entry5 tor");
    bus_write(2'd1, 4, 32'h0000_4444, "R10 addr4 tor follow");
    bus_write(2'd1, 5, 32'h0000_5555, "R10 addr5 alone");

    // R12 and R6: bypass, then locking
    bus_write(2'd2, 0, 32'h4, "R12 set bypass");
    bus_read(2'd2, 0, "R12 bypass readback");
    bus_write(2'd0, 0, 32'h0081_0000, "R12 lock entry2");
    bus_write(2'd0, 0, 32'h0083_0000, "R12 locked cfg write");
    bus_write(2'd1, 2, 32'h0000_2222, "R12 locked addr write");
    bus_write(2'd0, 1, 32'h0000_8800, "R12 lock tor entry5");
    bus_read(2'd0, 1, "R12 tor entry readback");
    bus_write(2'd2, 0, 32'h0, "R6 clear bypass");
    bus_write(2'd2, 0, 32'h4, "R6 bypass refused");
    bus_read(2'd2, 0, "R6 bypass stays clear");

    // R3 and R4
    bus_write(2'd0, 0, 32'h0000_0000, "R3 locked cfg");
    bus_read(2'd0, 0, "R3 cfg unchanged");
    bus_write(2'd1, 2, 32'h0BAD_0002, "R3 locked addr");
    bus_read(2'd1, 2, "R3 addr unchanged");
    bus_write(2'd1, 4, 32'h0BAD_0004, "R4 tor guarded");
    bus_read(2'd1, 4, "R4 addr unchanged");
    bus_write(2'd1, 3, 32'h0000_3333, "R4 other addr");
    bus_read(2'd1, 3, "R4 other addr readback");

    // R6: sticky policy bits
    bus_write(2'd2, 0, 32'h1, "R6 set lockdown");
    bus_write(2'd2, 0, 32'h0, "R6 lockdown sticky");
    bus_write(2'd2, 0, 32'h2, "R6 set whitelist");
    bus_write(2'd2, 0, 32'h0, "R6 whitelist sticky");
    bus_read(2'd2, 0, "R6 sticky readback");

    // R5: every byte value under lockdown, locked and unlocked entries
    for (int v = 0; v < 256; v++) begin
      logic [XL-1:0] w = {4{8'(v)}};
      bus_write(2'd0, 3, w, "R5 lockdown sweep hi");
      bus_read(2'd0, 3, "R5 lockdown readback hi");
      bus_write(2'd0, 0, w ^ 32'h0000_8000, "R5 lockdown sweep lo");
      bus_read(2'd0, 0, "R5 lockdown readback lo");
      if (v % 64 == 0) bus_write(2'd0, 3, 32'h0, "R5 lockdown reset try");
    end

    // R7: base variant
    b_wr(2'd2, 0, 32'h7);
    b_rdchk(2'd2, 0, 32'h0, "R7 policy forced zero");
    chk("R7 policy pins", {29'd0, b_rlb, b_mmwp, b_mml}, 32'd0);
    b_wr(2'd0, 0, 32'h0000_0080);
    b_rdchk(2'd0, 0, 32'h0000_0080, "R7 lock set");
    b_wr(2'd2, 0, 32'h4);
    b_wr(2'd0, 0, 32'h0000_0000);
    b_rdchk(2'd0, 0, 32'h0000_0080, "R7 no bypass");
    b_wr(2'd1, 0, 32'h1234_5678);
    b_rdchk(2'd1, 0, 32'h0, "R7 locked addr");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule